// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the condition and control flags of a small 16-bit processor. It watches the result bus of the arithmetic unit. Under a separate enable for each flag, it records whether the result is negative or zero, whether a carry left the word, and whether a signed overflow occurred. Other controls set the break flag, turn the interrupt-enable flag on or off, and gate incoming interrupt requests through that flag.

All flags are always available packed into one status byte. The sequencer pushes this byte to the stack when it enters an interrupt. On return from the interrupt, the sequencer presents the saved byte on a restore port, and the block reloads every flag from it in a single cycle. The block has no decimal-mode flag, and that bit position always reads zero.

Top module: `psw_flag_reg`

## Requirements
- R1: A clock edge with `rst_n` low loads the status byte 0x84: negative and interrupt-enable are 1, and all other flags are 0.
- R2: The status byte places carry at bit 0, zero at bit 1, interrupt-enable at bit 2, break at bit 4, overflow at bit 6 and negative at bit 7. Bits 3 and 5 always read 0.
- R3: When `upd_en[3]` is high, negative takes bit 15 of `alu_result`.
- R4: When `upd_en[1]` is high, zero becomes 1 exactly when `alu_result` is 0x0000.
- R5: When `upd_en[0]` is high, carry becomes the OR of `alu_add_wrap` (a 16-bit add wrapped past 0xFFFF) and `alu_shift_out` (a 1 was shifted or rotated out).
- R6: When `upd_en[2]` is high, overflow takes `alu_ovf`.
- R7: A flag whose enable bit is low keeps its previous value, whatever the result bus carries.
- R8: A high `brk_strobe` sets break. Break then stays set until a restore or a reset.
- R9: `ie_set` sets interrupt-enable and `ie_clr` clears it. When both are high in the same cycle, clear wins.
- R10: `irq_take` is high only when `irq_req` is high and interrupt-enable is 1.
- R11: A high `restore_en` loads all six flags from the matching bits of `restore_byte` in one cycle. Bits 3 and 5 of `restore_byte` are ignored.
- R12: In a cycle with `restore_en` high, the restore overrides any arithmetic update, break strobe or interrupt-enable control given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_result | input | 16 | Result word of the current arithmetic operation |
| alu_add_wrap | input | 1 | The add wrapped past the top of the word |
| alu_shift_out | input | 1 | A 1 was shifted or rotated out |
| alu_ovf | input | 1 | Signed overflow of the current operation |
| upd_en | input | 4 | Per-flag update enables: [0] carry, [1] zero, [2] overflow, [3] negative |
| brk_strobe | input | 1 | A break instruction is executing |
| ie_set | input | 1 | Enable interrupts |
| ie_clr | input | 1 | Disable interrupts |
| restore_en | input | 1 | Reload all flags from `restore_byte` |
| restore_byte | input | 8 | Saved status byte to reload |
| irq_req | input | 1 | Pending interrupt request |
| status_byte | output | 8 | Packed flags |
| irq_take | output | 1 | Interrupt request accepted under interrupt-enable |

## Verification
Every flag change driven from the inputs shows in `status_byte` one rising edge after the cycle in which the inputs were held. `irq_take` combines the live request with the interrupt-enable flag as registered at that same edge. The bench drives inputs on the falling edge and queues the expected byte and gate value. Its monitor compares them a quarter period after the following rising edge, while the request input is still held. The reset value is checked directly, both after the initial reset and after a reset applied in mid-run.

// File: rtl/psw_pkg.sv
// Package psw_pkg
// Shared layout of the status flags. The bit positions are fixed because the
// interrupt-entry and return sequences push and reload the packed byte.
package psw_pkg;

    localparam int unsigned PSW_W     = 8;
    localparam int unsigned ARITH_N   = 4;

    localparam int unsigned POS_CARRY = 0;
    localparam int unsigned POS_ZERO  = 1;
    localparam int unsigned POS_IE    = 2;
    localparam int unsigned POS_BRK   = 4;
    localparam int unsigned POS_OVF   = 6;
    localparam int unsigned POS_NEG   = 7;

    localparam int unsigned UPD_CARRY = 0;
    localparam int unsigned UPD_ZERO  = 1;
    localparam int unsigned UPD_OVF   = 2;
    localparam int unsigned UPD_NEG   = 3;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic brk;
        logic ie;
        logic zero;
        logic carry;
    } psw_flags_t;

    localparam psw_flags_t PSW_RESET = '{neg: 1'b1, ovf: 1'b0, brk: 1'b0,
                                         ie: 1'b1, zero: 1'b0, carry: 1'b0};

endpackage

// File: rtl/psw_arith_eval.sv
// Module psw_arith_eval
// Derives candidate values for the four arithmetic flags from one ALU result.
// Assumes the ALU reports add wrap, shift-out and signed overflow separately.
module psw_arith_eval
    import psw_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0]  result,
    input  logic               add_wrap,
    input  logic               shift_out,
    input  logic               ovf_in,
    output logic [ARITH_N-1:0] cand
);

    // Candidate flag values, indexed by the update-enable bit order.
    always_comb begin
        cand            = '0;
        cand[UPD_NEG]   = result[DATA_W-1];
        cand[UPD_ZERO]  = (result == '0);
        cand[UPD_CARRY] = add_wrap | shift_out;
        cand[UPD_OVF]   = ovf_in;
    end

endmodule

// File: rtl/psw_pack.sv
// Module psw_pack
// Converts between the flag struct and the 8-bit status byte. Packing drives
// the unused positions to zero. Unpacking reads only the six flag positions.
module psw_pack
    import psw_pkg::*;
(
    input  psw_flags_t       flags_in,
    output logic [PSW_W-1:0] byte_out,
    input  logic [PSW_W-1:0] byte_in,
    output psw_flags_t       flags_out
);

    // Place each flag at its fixed position, leaving the rest zero.
    always_comb begin
        byte_out            = '0;
        byte_out[POS_NEG]   = flags_in.neg;
        byte_out[POS_OVF]   = flags_in.ovf;
        byte_out[POS_BRK]   = flags_in.brk;
        byte_out[POS_IE]    = flags_in.ie;
        byte_out[POS_ZERO]  = flags_in.zero;
        byte_out[POS_CARRY] = flags_in.carry;
    end

    // Pick each flag out of a saved byte.
    always_comb begin
        flags_out.neg   = byte_in[POS_NEG];
        flags_out.ovf   = byte_in[POS_OVF];
        flags_out.brk   = byte_in[POS_BRK];
        flags_out.ie    = byte_in[POS_IE];
        flags_out.zero  = byte_in[POS_ZERO];
        flags_out.carry = byte_in[POS_CARRY];
    end

endmodule

// File: rtl/psw_next_state.sv
// Module psw_next_state
// Next-state priority for all flags. Restore beats everything. Below that, each
// arithmetic flag follows its own enable, break is sticky-set, and the
// interrupt-enable clear beats the set.
module psw_next_state
    import psw_pkg::*;
(
    input  psw_flags_t         cur,
    input  logic [ARITH_N-1:0] cand,
    input  logic [ARITH_N-1:0] upd_en,
    input  logic               brk_strobe,
    input  logic               ie_set,
    input  logic               ie_clr,
    input  logic               restore_en,
    input  psw_flags_t         restored,
    output psw_flags_t         nxt
);

    logic [ARITH_N-1:0] arith_cur;
    logic [ARITH_N-1:0] arith_nxt;

    // Gather the current arithmetic flags in update-enable order.
    always_comb begin
        arith_cur            = '0;
        arith_cur[UPD_NEG]   = cur.neg;
        arith_cur[UPD_ZERO]  = cur.zero;
        arith_cur[UPD_CARRY] = cur.carry;
        arith_cur[UPD_OVF]   = cur.ovf;
    end

    // One hold-or-update selector per arithmetic flag.
    for (genvar i = 0; i < ARITH_N; i++) begin : g_arith
        assign arith_nxt[i] = upd_en[i] ? cand[i] : arith_cur[i];
    end

    // Combine all sources, with restore on top.
    always_comb begin
        if (restore_en) begin
            nxt = restored;
        end else begin
            nxt.neg   = arith_nxt[UPD_NEG];
            nxt.zero  = arith_nxt[UPD_ZERO];
            nxt.carry = arith_nxt[UPD_CARRY];
            nxt.ovf   = arith_nxt[UPD_OVF];
            nxt.brk   = cur.brk | brk_strobe;
            if (ie_clr) begin
                nxt.ie = 1'b0;
            end else if (ie_set) begin
                nxt.ie = 1'b1;
            end else begin
                nxt.ie = cur.ie;
            end
        end
    end

endmodule

// File: rtl/psw_flag_reg.sv
// Module psw_flag_reg
// Status flag register of a small 16-bit processor. It holds six flags and
// shows them as one packed byte. It accepts ALU updates, a break strobe,
// interrupt-enable controls and a whole-byte restore. Synchronous active-low reset.
module psw_flag_reg
    import psw_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  alu_result,
    input  logic               alu_add_wrap,
    input  logic               alu_shift_out,
    input  logic               alu_ovf,
    input  logic [ARITH_N-1:0] upd_en,
    input  logic               brk_strobe,
    input  logic               ie_set,
    input  logic               ie_clr,
    input  logic               restore_en,
    input  logic [PSW_W-1:0]   restore_byte,
    input  logic               irq_req,
    output logic [PSW_W-1:0]   status_byte,
    output logic               irq_take
);

    psw_flags_t         flags_q;
    psw_flags_t         flags_d;
    psw_flags_t         restored;
    logic [ARITH_N-1:0] cand;

    psw_arith_eval #(
        .DATA_W (DATA_W)
    ) u_eval (
        .result    (alu_result),
        .add_wrap  (alu_add_wrap),
        .shift_out (alu_shift_out),
        .ovf_in    (alu_ovf),
        .cand      (cand)
    );

    psw_pack u_pack (
        .flags_in  (flags_q),
        .byte_out  (status_byte),
        .byte_in   (restore_byte),
        .flags_out (restored)
    );

    psw_next_state u_next (
        .cur        (flags_q),
        .cand       (cand),
        .upd_en     (upd_en),
        .brk_strobe (brk_strobe),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .restore_en (restore_en),
        .restored   (restored),
        .nxt        (flags_d)
    );

    // Flag storage with synchronous reset to the power-up pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= PSW_RESET;
        end else begin
            flags_q <= flags_d;
        end
    end

    // Let a request through only while interrupts are enabled.
    assign irq_take = irq_req & flags_q.ie;

endmodule

// File: rtl/psw_flag_reg_chk.sv
// Module psw_flag_reg_chk
// Port-level properties of psw_flag_reg. This checker is bound to every instance.
module psw_flag_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] alu_result,
    input logic        alu_add_wrap,
    input logic        alu_shift_out,
    input logic        alu_ovf,
    input logic [3:0]  upd_en,
    input logic        brk_strobe,
    input logic        ie_clr,
    input logic        restore_en,
    input logic [7:0]  restore_byte,
    input logic        irq_req,
    input logic [7:0]  status_byte,
    input logic        irq_take
);

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> status_byte == 8'h84);

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[5] == 1'b0 && status_byte[3] == 1'b0);

    assert_neg_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && upd_en[3]) |=> status_byte[7] == $past(alu_result[15]));

    assert_zero_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && upd_en[1]) |=> status_byte[1] == ($past(alu_result) == 16'h0000));

    assert_carry_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && upd_en[0]) |=>
            status_byte[0] == ($past(alu_add_wrap) || $past(alu_shift_out)));

    assert_ovf_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && upd_en[2]) |=> status_byte[6] == $past(alu_ovf));

    assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && !upd_en[2]) |=> $stable(status_byte[6]));

    assert_brk_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && brk_strobe) |=> status_byte[4]);

    assert_ie_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && ie_clr) |=> !status_byte[2]);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_req && status_byte[2]));

    assert_restore_R11_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> status_byte == ($past(restore_byte) & 8'hD7));

endmodule

bind psw_flag_reg psw_flag_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alu_result    (alu_result),
    .alu_add_wrap  (alu_add_wrap),
    .alu_shift_out (alu_shift_out),
    .alu_ovf       (alu_ovf),
    .upd_en        (upd_en),
    .brk_strobe    (brk_strobe),
    .ie_clr        (ie_clr),
    .restore_en    (restore_en),
    .restore_byte  (restore_byte),
    .irq_req       (irq_req),
    .status_byte   (status_byte),
    .irq_take      (irq_take)
);

// File: tb/psw_flag_reg_tb.sv
// Scoreboard bench for psw_flag_reg. The driver task applies one cycle of
// stimulus, updates a reference model and queues the expected outputs.
// The monitor compares them a quarter period after the following rising edge.
module psw_flag_reg_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] exp_byte;
        logic       exp_irq;
        string      tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] alu_result = '0;
    logic        alu_add_wrap = 1'b0;
    logic        alu_shift_out = 1'b0;
    logic        alu_ovf = 1'b0;
    logic [3:0]  upd_en = '0;
    logic        brk_strobe = 1'b0;
    logic        ie_set = 1'b0;
    logic        ie_clr = 1'b0;
    logic        restore_en = 1'b0;
    logic [7:0]  restore_byte = '0;
    logic        irq_req = 1'b0;
    logic [7:0]  status_byte;
    logic        irq_take;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    exp_item_t sb_q[$];

    // Reference model flags.
    logic m_n, m_v, m_b, m_i, m_z, m_c;

    psw_flag_reg u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .alu_result    (alu_result),
        .alu_add_wrap  (alu_add_wrap),
        .alu_shift_out (alu_shift_out),
        .alu_ovf       (alu_ovf),
        .upd_en        (upd_en),
        .brk_strobe    (brk_strobe),
        .ie_set        (ie_set),
        .ie_clr        (ie_clr),
        .restore_en    (restore_en),
        .restore_byte  (restore_byte),
        .irq_req       (irq_req),
        .status_byte   (status_byte),
        .irq_take      (irq_take)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model_byte();
        return {m_n, m_v, 1'b0, m_b, 1'b0, m_i, m_z, m_c};
    endfunction

    task automatic model_reset();
        m_n = 1'b1; m_v = 1'b0; m_b = 1'b0; m_i = 1'b1; m_z = 1'b0; m_c = 1'b0;
    endtask

    task automatic check_now(input logic [7:0] exp_b, input string tag);
        n_checks++;
        if (status_byte !== exp_b) begin
            n_fail++;
            $display("FAIL %s status actual=%02h expected=%02h", tag, status_byte, exp_b);
        end
    endtask

    // Driver: one cycle of stimulus, model update and queued expectation.
    task automatic step(input logic [15:0] res, input logic wrap, input logic shout,
                        input logic ovf, input logic [3:0] en, input logic brk,
                        input logic iset, input logic iclr, input logic rst_en,
                        input logic [7:0] rb, input logic irq, input string tag);
        exp_item_t it;
        @(negedge clk);
        alu_result = res; alu_add_wrap = wrap; alu_shift_out = shout; alu_ovf = ovf;
        upd_en = en; brk_strobe = brk; ie_set = iset; ie_clr = iclr;
        restore_en = rst_en; restore_byte = rb; irq_req = irq;
        if (rst_en) begin
            m_n = rb[7]; m_v = rb[6]; m_b = rb[4]; m_i = rb[2]; m_z = rb[1]; m_c = rb[0];
        end else begin
            if (en[3]) m_n = res[15];
            if (en[2]) m_v = ovf;
            if (en[1]) m_z = (res == 16'h0000);
            if (en[0]) m_c = wrap | shout;
            if (brk)   m_b = 1'b1;
            if (iclr)      m_i = 1'b0;
            else if (iset) m_i = 1'b1;
        end
        it.exp_byte = model_byte();
        it.exp_irq  = irq & m_i;
        it.tag      = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the queued expectation after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (status_byte !== it.exp_byte) begin
                    n_fail++;
                    $display("FAIL %s status actual=%02h expected=%02h",
                             it.tag, status_byte, it.exp_byte);
                end
                n_checks++;
                if (irq_take !== it.exp_irq) begin
                    n_fail++;
                    $display("FAIL %s irq_take actual=%0b expected=%0b",
                             it.tag, irq_take, it.exp_irq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL all-requirements watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check_now(8'h84, "R1 reset value");
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R5 R3: wrapping add to zero updates N, Z and C together
        step(16'h0000, 1'b1, 1'b0, 1'b0, 4'b1011, 0, 0, 0, 0, 8'h00, 0, "R4_R5_R3 add wrap to zero");
        // R3 R7: only negative is enabled
        step(16'h8001, 1'b0, 1'b0, 1'b1, 4'b1000, 0, 0, 0, 0, 8'h00, 0, "R3_R7 negative only");
        // R6: overflow set
        step(16'h7FFF, 1'b0, 1'b0, 1'b1, 4'b0100, 0, 0, 0, 0, 8'h00, 0, "R6 overflow set");
        // R5: shift-out sets carry
        step(16'h1234, 1'b0, 1'b1, 1'b0, 4'b0001, 0, 0, 0, 0, 8'h00, 0, "R5 shift out carry");
        // R4: nonzero result clears zero
        step(16'h0001, 1'b0, 1'b0, 1'b0, 4'b0010, 0, 0, 0, 0, 8'h00, 0, "R4 nonzero clears zero");
        // R7: nothing enabled, bus noise ignored
        step(16'h0000, 1'b1, 1'b1, 1'b0, 4'b0000, 0, 0, 0, 0, 8'h00, 0, "R7 no enables hold");
        // R3 R6 R5: clear negative, overflow and carry
        step(16'h4000, 1'b0, 1'b0, 1'b0, 4'b1101, 0, 0, 0, 0, 8'h00, 0, "R3_R6_R5 clear flags");
        // R8: break strobe then sticky
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 1, 0, 0, 0, 8'h00, 0, "R8 break set");
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 0, 0, 0, 8'h00, 0, "R8 break sticky");
        // R10: request passes while enabled
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 0, 0, 0, 8'h00, 1, "R10 irq passes enabled");
        // R9 R10: clear enable, request blocked
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 0, 1, 0, 8'h00, 1, "R9_R10 ie clear blocks irq");
        // R9 R10: set enable, request passes
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 1, 0, 0, 8'h00, 1, "R9_R10 ie set passes irq");
        // R9: set and clear together, clear wins
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 1, 1, 0, 8'h00, 1, "R9 clear beats set");
        // R11 R2: restore all ones, bits 3 and 5 read zero
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 0, 0, 1, 8'hFF, 1, "R11_R2 restore FF");
        // R12: restore zero beats arithmetic update, break and ie set
        step(16'h8000, 1'b1, 1'b1, 1'b1, 4'b1111, 1, 1, 0, 1, 8'h00, 1, "R12 restore priority");
        // R11: only ignored bits set
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 0, 0, 1, 8'h28, 0, "R11 ignored bits");
        // R11: mixed pattern
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 0, 0, 1, 8'h53, 1, "R11 restore 53");
        step(16'h0000, 1'b0, 1'b0, 1'b0, 4'b0000, 0, 0, 0, 0, 8'h00, 0, "R11 idle after restore");

        repeat (3) @(posedge clk);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(posedge clk);
        #(CLK_PERIOD/4);
        check_now(8'h84, "R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule